// File: doc/BRIEF.md
# Descriptor Ring Fetch and Writeback Cache

This block keeps count of a window of 16-byte DMA descriptors taken from one circular ring in host memory. Four ring settings describe the ring: a base address, a byte length (the ring holds that length divided by 16 descriptors), a software-owned tail index and a head index owned by the block. The block reads descriptors in bursts. Each burst runs from a private fetch pointer toward the tail, so the cache fills as software posts work. The consumer takes cached descriptors one at a time. Each descriptor it takes is counted as used until a writeback burst hands it back to memory and moves the head forward.

DMA happens through two request/complete handshakes, one for reads and one for writebacks. A request is a one-cycle pulse that carries a byte address and a descriptor count. The engine answers with a one-cycle completion pulse, and each direction allows only one request in flight. No burst ever runs past the last slot of the ring. A writeback request carries an alignment mask that trims the burst to a multiple of an aligned group. If a request with a stricter mask arrives while a writeback is in flight, it is held and chained on once the current burst completes. The block stores no descriptor contents, only counts, pointers and indices.

Top module: `desc_ring_cache`

## Requirements
- R1: The ring length in descriptors is the byte-length input shifted right by four. The fetch span is tail minus fetch pointer when the tail is at or above the pointer. Otherwise it is ring length minus pointer, so a burst ends at the last slot at most. The fetch address is base plus pointer times 16.
- R2: A fetch burst's count is the smaller of the span and the free slots, where free slots are capacity (16) minus the used and unused entries held. The used plus unused total never exceeds capacity.
- R3: No fetch is issued when its count would be zero, and none is issued while an earlier fetch has not completed.
- R4: On fetch completion the unused count grows by the burst count, and the fetch pointer advances by it, wrapping to zero when it reaches the ring length.
- R5: The consumer port reports a descriptor ready while unused entries exist and shows the ring index of the oldest one, wrapping at the ring length. A take moves one entry from unused to used. A take with no unused entry changes nothing.
- R6: A writeback begins with the used count. If head plus that count reaches or passes the ring length, the burst is cut to ring length minus head, the remainder is chained, and the burst ends at the last slot at most. Its address is base plus head times 16, and its count leaves the used total at once.
- R7: When the burst does not reach the ring end, a nonzero mask clears the count's bits that are set in the mask. A count that becomes zero issues no writeback.
- R8: A writeback request whose mask is numerically smaller than the in-flight burst's mask is stored and runs, with that mask, the cycle after the in-flight burst completes. A request with an equal or larger mask that arrives while a burst is in flight is ignored.
- R9: On writeback completion the head advances by the burst count modulo the ring length.
- R10: A flush, or a change of base, byte length or head (head is written through the head-write strobe), empties both counts and sets the fetch pointer and take index to zero. A change of base, length or head while used entries or a DMA transfer are pending raises a one-cycle error pulse. The same change with nothing pending raises no pulse.
- R11: The remaining-descriptor output equals the unused count plus the absolute difference between fetch pointer and tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_len | input | IDX_W+4 | Ring length in bytes |
| sw_tail | input | IDX_W | Software tail index |
| head_wr | input | 1 | Strobe that loads the head from head_val |
| head_val | input | IDX_W | New head index |
| flush | input | 1 | Empty the cache and zero the fetch pointer |
| rd_req | output | 1 | Fetch burst request pulse |
| rd_addr | output | ADDR_W | Fetch burst byte address |
| rd_cnt | output | CNT_W | Fetch burst descriptor count |
| rd_done | input | 1 | Fetch burst completion pulse |
| pop | input | 1 | Consumer takes one descriptor |
| pop_ok | output | 1 | An unused descriptor is available |
| pop_idx | output | IDX_W | Ring index of the oldest unused descriptor |
| wb_ask | input | 1 | Writeback request |
| wb_ask_mask | input | CNT_W | Alignment mask of the writeback request |
| wb_req | output | 1 | Writeback burst request pulse |
| wb_addr | output | ADDR_W | Writeback burst byte address |
| wb_cnt | output | CNT_W | Writeback burst descriptor count |
| wb_done | input | 1 | Writeback burst completion pulse |
| head | output | IDX_W | Current head index |
| used_cnt | output | CNT_W | Descriptors taken and not yet written back |
| unused_cnt | output | CNT_W | Fetched descriptors not yet taken |
| desc_left | output | IDX_W+1 | Remaining-descriptor count |
| area_err | output | 1 | Ring changed while work was pending |

## Verification
On every cycle the assertions check three things: the used plus unused total stays within capacity, no fetch burst and no writeback burst runs past the last ring slot, and no request pulse carries a zero count or overlaps an outstanding fetch. The bench scenarios cover what depends on values: the span and free-slot limits on the fetch count, the wrap of the fetch pointer and take index, and the writeback that is cut at the ring end and then chained under a stricter deferred mask. They also cover a mask that trims a writeback to nothing, an ignored looser request, and the error pulse that separates an area change with pending work from one without.

// File: rtl/drc_pkg.sv
package drc_pkg;
    // bytes per descriptor expressed as a shift
    localparam int DESC_SHIFT = 4;
    localparam int DESC_BYTES = 1 << DESC_SHIFT;
endpackage

// File: rtl/drc_fetch.sv
module drc_fetch
    import drc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  ring_len,
    input  logic [IDX_W-1:0]  tail,
    input  logic [CNT_W-1:0]  free_slots,
    input  logic              rd_done,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [IDX_W-1:0]  fetch_ptr,
    output logic              busy,
    output logic [CNT_W-1:0]  fill_cnt
);
    typedef struct packed {
        logic [IDX_W-1:0] fp;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             req;
    } fst_t;

    fst_t fs_d, fs_q;

    logic [IDX_W-1:0] span;
    logic [CNT_W-1:0] want;
    logic [IDX_W:0]   adv;

    always_comb begin
        fs_d     = fs_q;
        fs_d.req = 1'b0;
        span = (tail >= fs_q.fp) ? (tail - fs_q.fp) : (ring_len - fs_q.fp);
        if (ring_len == '0) begin
            span = '0;
        end
        want = ((IDX_W)'(free_slots) < span) ? free_slots : span[CNT_W-1:0];
        adv  = {1'b0, fs_q.fp} + (IDX_W+1)'(fs_q.cnt);
        if (fs_q.busy && rd_done) begin
            fs_d.busy = 1'b0;
            fs_d.fp   = (adv >= {1'b0, ring_len}) ? '0 : adv[IDX_W-1:0];
        end else if (!fs_q.busy && !clr && want != '0) begin
            fs_d.busy = 1'b1;
            fs_d.cnt  = want;
            fs_d.req  = 1'b1;
        end
        if (clr) begin
            fs_d.fp = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign rd_req    = fs_q.req;
    assign rd_cnt    = fs_q.cnt;
    assign rd_addr   = cfg_base + (ADDR_W)'({fs_q.fp, {DESC_SHIFT{1'b0}}});
    assign fetch_ptr = fs_q.fp;
    assign busy      = fs_q.busy;
    assign fill_cnt  = (fs_q.busy && rd_done) ? fs_q.cnt : '0;
endmodule

// File: rtl/drc_wb.sv
module drc_wb
    import drc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  ring_len,
    input  logic [CNT_W-1:0]  used_cnt,
    input  logic              ask,
    input  logic [CNT_W-1:0]  ask_mask,
    input  logic              wb_done,
    input  logic              head_wr,
    input  logic [IDX_W-1:0]  head_val,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [CNT_W-1:0]  wb_cnt,
    output logic [IDX_W-1:0]  head,
    output logic              inflight,
    output logic [CNT_W-1:0]  take_cnt
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mask;
        logic             more;
        logic             chain;
        logic             req;
    } wst_t;

    wst_t ws_d, ws_q;

    logic             start;
    logic [CNT_W-1:0] emask;
    logic [IDX_W:0]   reach;
    logic [IDX_W:0]   nh;
    logic [CNT_W-1:0] c;

    always_comb begin
        ws_d       = ws_q;
        ws_d.req   = 1'b0;
        ws_d.chain = 1'b0;
        take_cnt   = '0;
        start      = 1'b0;
        emask      = ws_q.mask;
        nh         = {1'b0, ws_q.head} + (IDX_W+1)'(ws_q.cnt);
        if (ws_q.out) begin
            if (wb_done) begin
                if (nh >= {1'b0, ring_len}) begin
                    nh = nh - {1'b0, ring_len};
                end
                ws_d.head  = nh[IDX_W-1:0];
                ws_d.out   = 1'b0;
                ws_d.chain = ws_q.more;
            end
            if (ask && ask_mask < ws_q.mask) begin
                ws_d.mask = ask_mask;
                ws_d.more = 1'b1;
                if (wb_done) begin
                    ws_d.chain = 1'b1;
                end
            end
        end else if (hold) begin
            ws_d.chain = ws_q.chain;
        end else if (ws_q.chain) begin
            start = 1'b1;
            emask = (ask && ask_mask < ws_q.mask) ? ask_mask : ws_q.mask;
        end else if (ask) begin
            start = 1'b1;
            emask = ask_mask;
        end

        reach = {1'b0, ws_q.head} + (IDX_W+1)'(used_cnt);
        c     = used_cnt;
        if (ring_len == '0) begin
            c = '0;
        end else if (reach >= {1'b0, ring_len}) begin
            c = (CNT_W)'(ring_len - ws_q.head);
        end else begin
            c = used_cnt & ~emask;
        end

        if (start) begin
            ws_d.mask = emask;
            ws_d.more = (ring_len != '0) && (reach >= {1'b0, ring_len});
            if (c != '0) begin
                ws_d.out = 1'b1;
                ws_d.cnt = c;
                ws_d.req = 1'b1;
                take_cnt = c;
            end
        end
        if (head_wr) begin
            ws_d.head = head_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q <= '0;
        end else begin
            ws_q <= ws_d;
        end
    end

    assign wb_req   = ws_q.req;
    assign wb_cnt   = ws_q.cnt;
    assign wb_addr  = cfg_base + (ADDR_W)'({ws_q.head, {DESC_SHIFT{1'b0}}});
    assign head     = ws_q.head;
    assign inflight = ws_q.out;
endmodule

// File: rtl/desc_ring_cache.sv
module desc_ring_cache
    import drc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12,
    parameter int CAP    = 16,
    localparam int CNT_W = $clog2(CAP + 1),
    localparam int LEN_W = IDX_W + DESC_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [IDX_W-1:0]  sw_tail,
    input  logic              head_wr,
    input  logic [IDX_W-1:0]  head_val,
    input  logic              flush,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_cnt,
    input  logic              rd_done,
    input  logic              pop,
    output logic              pop_ok,
    output logic [IDX_W-1:0]  pop_idx,
    input  logic              wb_ask,
    input  logic [CNT_W-1:0]  wb_ask_mask,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [CNT_W-1:0]  wb_cnt,
    input  logic              wb_done,
    output logic [IDX_W-1:0]  head,
    output logic [CNT_W-1:0]  used_cnt,
    output logic [CNT_W-1:0]  unused_cnt,
    output logic [IDX_W:0]    desc_left,
    output logic              area_err
);
    typedef struct packed {
        logic [CNT_W-1:0]  unused;
        logic [CNT_W-1:0]  used;
        logic [IDX_W-1:0]  cons;
        logic [ADDR_W-1:0] prev_base;
        logic [LEN_W-1:0]  prev_len;
        logic              err;
    } tst_t;

    tst_t ts_d, ts_q;

    logic [IDX_W-1:0] ring_len;
    logic [CNT_W-1:0] free_slots;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] take_cnt;
    logic [IDX_W-1:0] fetch_ptr;
    logic             fetch_busy;
    logic             wb_inflight;
    logic             area_chg;
    logic             clr;
    logic             pop_fire;
    logic [IDX_W-1:0] gap;

    assign ring_len   = cfg_len[LEN_W-1:DESC_SHIFT];
    assign free_slots = (CNT_W)'(CAP) - ts_q.used - ts_q.unused;
    assign area_chg   = (cfg_base != ts_q.prev_base) || (cfg_len != ts_q.prev_len) || head_wr;
    assign clr        = flush || area_chg;
    assign pop_fire   = pop && (ts_q.unused != '0) && !clr;

    drc_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .cfg_base   (cfg_base),
        .ring_len   (ring_len),
        .tail       (sw_tail),
        .free_slots (free_slots),
        .rd_done    (rd_done),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_cnt     (rd_cnt),
        .fetch_ptr  (fetch_ptr),
        .busy       (fetch_busy),
        .fill_cnt   (fill_cnt)
    );

    drc_wb #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (clr),
        .cfg_base  (cfg_base),
        .ring_len  (ring_len),
        .used_cnt  (ts_q.used),
        .ask       (wb_ask),
        .ask_mask  (wb_ask_mask),
        .wb_done   (wb_done),
        .head_wr   (head_wr),
        .head_val  (head_val),
        .wb_req    (wb_req),
        .wb_addr   (wb_addr),
        .wb_cnt    (wb_cnt),
        .head      (head),
        .inflight  (wb_inflight),
        .take_cnt  (take_cnt)
    );

    always_comb begin
        ts_d           = ts_q;
        ts_d.prev_base = cfg_base;
        ts_d.prev_len  = cfg_len;
        ts_d.err       = area_chg && ((ts_q.used != '0) || fetch_busy || wb_inflight);
        ts_d.unused    = ts_q.unused + fill_cnt - (CNT_W)'(pop_fire);
        ts_d.used      = ts_q.used + (CNT_W)'(pop_fire) - take_cnt;
        if (pop_fire) begin
            ts_d.cons = ({1'b0, ts_q.cons} + 1'b1 >= {1'b0, ring_len}) ? '0 : ts_q.cons + 1'b1;
        end
        if (clr) begin
            ts_d.unused = '0;
            ts_d.used   = '0;
            ts_d.cons   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign gap        = (fetch_ptr >= sw_tail) ? (fetch_ptr - sw_tail) : (sw_tail - fetch_ptr);
    assign desc_left  = (IDX_W+1)'(ts_q.unused) + {1'b0, gap};
    assign pop_ok     = ts_q.unused != '0;
    assign pop_idx    = ts_q.cons;
    assign used_cnt   = ts_q.used;
    assign unused_cnt = ts_q.unused;
    assign area_err   = ts_q.err;
endmodule

// File: rtl/drc_chk.sv
module drc_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12,
    parameter int CAP    = 16,
    parameter int CNT_W  = 5,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              rd_req,
    input logic              rd_done,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  rd_cnt,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [CNT_W-1:0]  wb_cnt,
    input logic [CNT_W-1:0]  used_cnt,
    input logic [CNT_W-1:0]  unused_cnt
);
    logic              rd_open_q;
    logic [ADDR_W-1:0] len_w;
    logic [ADDR_W-1:0] rd_end;
    logic [ADDR_W-1:0] wb_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_open_q <= 1'b0;
        end else if (rd_req) begin
            rd_open_q <= 1'b1;
        end else if (rd_done) begin
            rd_open_q <= 1'b0;
        end
    end

    always_comb begin
        len_w  = (ADDR_W)'(cfg_len >> 4);
        rd_end = ((rd_addr - cfg_base) >> 4) + (ADDR_W)'(rd_cnt);
        wb_end = ((wb_addr - cfg_base) >> 4) + (ADDR_W)'(wb_cnt);
    end

    // R2
    occ_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((CNT_W+1)'(used_cnt) + (CNT_W+1)'(unused_cnt)) <= (CNT_W+1)'(CAP));

    // R3
    single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !rd_open_q);

    // R3
    fetch_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_cnt != '0);

    // R1
    fetch_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_end <= len_w);

    // R6
    wb_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_end <= len_w && wb_cnt != '0));
endmodule

bind desc_ring_cache drc_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP(CAP), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/desc_ring_cache_bench.sv
`timescale 1ns/1ps
module desc_ring_cache_bench;
    localparam int AW = 32;
    localparam int IW = 12;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [IW+3:0] cfg_len = '0;
    logic [IW-1:0] sw_tail = '0;
    logic          head_wr = 1'b0;
    logic [IW-1:0] head_val = '0;
    logic          flush = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] rd_cnt;
    logic          rd_done = 1'b0;
    logic          pop = 1'b0;
    logic          pop_ok;
    logic [IW-1:0] pop_idx;
    logic          wb_ask = 1'b0;
    logic [CW-1:0] wb_ask_mask = '0;
    logic          wb_req;
    logic [AW-1:0] wb_addr;
    logic [CW-1:0] wb_cnt;
    logic          wb_done = 1'b0;
    logic [IW-1:0] head;
    logic [CW-1:0] used_cnt;
    logic [CW-1:0] unused_cnt;
    logic [IW:0]   desc_left;
    logic          area_err;

    int total = 0;
    int fails = 0;
    int err_seen = 0;

    always #2 clk = ~clk;

    desc_ring_cache u_desc_ring_cache (.*);

    always @(negedge clk) if (rst_n && area_err) err_seen++;

    typedef struct packed {
        logic [15:0] len_b;
        logic [11:0] tail;
        logic [4:0]  exp;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{16'd512, 12'd5,  5'd5},
        '{16'd512, 12'd20, 5'd16},
        '{16'd512, 12'd0,  5'd0},
        '{16'd128, 12'd7,  5'd7},
        '{16'd160, 12'd9,  5'd9}
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic clear_strobes();
        flush = 1'b0; head_wr = 1'b0; pop = 1'b0; wb_ask = 1'b0;
    endtask

    task automatic get_rd(input int maxc, output bit seen, output int cnt, output int addr);
        seen = 0; cnt = 0; addr = 0;
        for (int i = 0; i < maxc; i++) begin
            if (seen) break;
            @(negedge clk);
            clear_strobes();
            if (rd_req) begin
                seen = 1; cnt = int'(rd_cnt); addr = int'(rd_addr);
            end
        end
    endtask

    task automatic get_wb(input int maxc, output bit seen, output int cnt, output int addr);
        seen = 0; cnt = 0; addr = 0;
        for (int i = 0; i < maxc; i++) begin
            if (seen) break;
            @(negedge clk);
            clear_strobes();
            if (wb_req) begin
                seen = 1; cnt = int'(wb_cnt); addr = int'(wb_addr);
            end
        end
    endtask

    task automatic rd_complete();
        @(negedge clk) rd_done = 1'b1;
        @(negedge clk) rd_done = 1'b0;
    endtask

    task automatic wb_complete();
        @(negedge clk) wb_done = 1'b1;
        @(negedge clk) wb_done = 1'b0;
    endtask

    task automatic take_n(input int n, input int first, input int len);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R5", "pop_ok", int'(pop_ok), 1);
            chk("R5", "pop_idx", int'(pop_idx), (first + i) % len);
            pop = 1'b1;
        end
        @(negedge clk) pop = 1'b0;
    endtask

    initial begin
        #80000;
        fails++;
        total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit s;
        int c, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R4, R9, R11)
        chk("R4", "reset unused", int'(unused_cnt), 0);
        chk("R5", "reset pop_ok", int'(pop_ok), 0);
        chk("R9", "reset head", int'(head), 0);
        chk("R11", "reset desc_left", int'(desc_left), 0);
        chk("R3", "reset rd_req", int'(rd_req), 0);

        cfg_base = 32'h1000;
        cfg_len  = 16'd160;
        repeat (2) @(negedge clk);
        // R5: take with empty cache is ignored
        pop = 1'b1;
        @(negedge clk) pop = 1'b0;
        @(negedge clk);
        chk("R5", "empty take used", int'(used_cnt), 0);
        chk("R5", "empty take unused", int'(unused_cnt), 0);

        // vector table: fetch count from span and free slots (R1, R2, R3)
        for (int v = 0; v < 5; v++) begin
            @(negedge clk);
            cfg_len = VEC[v].len_b;
            sw_tail = VEC[v].tail;
            flush = 1'b1;
            get_rd(6, s, c, a);
            if (VEC[v].exp == 0) begin
                chk("R3", "zero-count fetch seen", int'(s), 0);
            end else begin
                chk("R1", "fetch seen", int'(s), 1);
                chk("R2", "fetch count", c, int'(VEC[v].exp));
                chk("R1", "fetch addr", a, 32'h1000);
                rd_complete();
                chk("R4", "unused after fill", int'(unused_cnt), int'(VEC[v].exp));
            end
        end
        chk("R10", "no error without pending work", err_seen, 0);

        // ring of 10 descriptors
        @(negedge clk);
        sw_tail = 12'd6;
        flush = 1'b1;
        get_rd(6, s, c, a);
        chk("R1", "first fetch count", c, 6);
        chk("R1", "first fetch addr", a, 32'h1000);
        rd_complete();
        chk("R4", "unused 6", int'(unused_cnt), 6);
        chk("R11", "desc_left 6", int'(desc_left), 6);

        take_n(4, 0, 10);
        chk("R5", "used 4", int'(used_cnt), 4);

        @(negedge clk); wb_ask = 1'b1; wb_ask_mask = 5'd0;
        get_wb(6, s, c, a);
        chk("R6", "wb count", c, 4);
        chk("R6", "wb addr", a, 32'h1000);
        chk("R6", "used after issue", int'(used_cnt), 0);
        wb_complete();
        chk("R9", "head 4", int'(head), 4);

        // tail below pointer: burst stops at ring end, then wraps (R1, R4)
        @(negedge clk) sw_tail = 12'd3;
        get_rd(6, s, c, a);
        chk("R1", "end burst count", c, 4);
        chk("R1", "end burst addr", a, 32'h1060);
        rd_complete();
        get_rd(6, s, c, a);
        chk("R4", "wrapped fetch count", c, 3);
        chk("R4", "wrapped fetch addr", a, 32'h1000);
        rd_complete();
        chk("R4", "unused 9", int'(unused_cnt), 9);

        take_n(9, 4, 10);

        // writeback cut at ring end, stricter request deferred (R6, R8, R7)
        @(negedge clk); wb_ask = 1'b1; wb_ask_mask = 5'd3;
        get_wb(6, s, c, a);
        chk("R6", "cut wb count", c, 6);
        chk("R6", "cut wb addr", a, 32'h1040);
        chk("R6", "used 3", int'(used_cnt), 3);
        @(negedge clk); wb_ask = 1'b1; wb_ask_mask = 5'd1;
        get_wb(5, s, c, a);
        chk("R8", "no wb while busy", int'(s), 0);
        wb_complete();
        chk("R9", "head wraps to 0", int'(head), 0);
        get_wb(6, s, c, a);
        chk("R8", "chained wb seen", int'(s), 1);
        chk("R7", "chained wb masked count", c, 2);
        chk("R8", "chained wb addr", a, 32'h1000);
        @(negedge clk); wb_ask = 1'b1; wb_ask_mask = 5'd3;
        get_wb(3, s, c, a);
        wb_complete();
        get_wb(6, s, c, a);
        chk("R8", "looser request ignored", int'(s), 0);
        chk("R9", "head 2", int'(head), 2);
        chk("R8", "used 1", int'(used_cnt), 1);

        // mask trims count to zero (R7)
        @(negedge clk); wb_ask = 1'b1; wb_ask_mask = 5'd1;
        get_wb(5, s, c, a);
        chk("R7", "zero masked wb", int'(s), 0);
        chk("R7", "used kept", int'(used_cnt), 1);

        // head write with used pending (R10)
        @(negedge clk); head_wr = 1'b1; head_val = 12'd0;
        get_rd(6, s, c, a);
        chk("R10", "error pulse", err_seen, 1);
        chk("R10", "used cleared", int'(used_cnt), 0);
        chk("R10", "unused cleared", int'(unused_cnt), 0);
        chk("R10", "head loaded", int'(head), 0);
        chk("R10", "fetch from zero addr", a, 32'h1000);
        chk("R10", "fetch from zero count", c, 3);
        @(negedge clk) sw_tail = 12'd7;
        get_rd(5, s, c, a);
        chk("R3", "no fetch while outstanding", int'(s), 0);
        rd_complete();
        chk("R11", "desc_left with gap", int'(desc_left), 7);
        get_rd(6, s, c, a);
        chk("R4", "next fetch addr", a, 32'h1030);
        chk("R4", "next fetch count", c, 4);
        rd_complete();
        chk("R11", "desc_left 7", int'(desc_left), 7);
        chk("R4", "unused 7", int'(unused_cnt), 7);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule